// File: doc/BRIEF.md
# Timer DMA Request Generator

This block drives the DMA request lines of a waveform timer. There is one overflow request line and one request line for each compare/capture channel. The timer core supplies event strobes: overflow, underflow, retrigger, per-channel compare match and per-channel capture-valid. It also supplies strobes that mark the phase boundaries of the two-ramp and dual-slope counting modes. The block turns these strobes into level requests. Each request stays high until its own clearing condition arrives. For the overflow line and the compare channels, that condition is a DMA acknowledge. For a capture channel, it is a read of that channel's capture register.

The overflow line has a one-shot arming mode. While that mode is on, a software command arms the line, and the next update event after the command raises a single request. The same mode silences the compare channels. When a channel uses a circular buffer in the two-ramp or dual-slope mode, the trigger points move. The channel fires at the start of ramp B, or at the start of the down-count. The overflow line fires at the start of ramp A, or at the start of the up-count. This lets two DMA channels refill the buffer registers for each half of the period safely.

Top module: `tmr_dma_req`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ovf_req and every ch_req bit are 0 and no one-shot command is remembered.
- R2: With one-shot mode off and no circular trigger active, any of evt_ovf, evt_unf or evt_retrig sets ovf_req at the next clock edge.
- R3: With one-shot mode on, a one-shot command arms the overflow line from the following cycle. The first update event seen while armed sets ovf_req and consumes the arm. Update events seen while not armed raise nothing.
- R4: A one-shot command given while one-shot mode is off has no effect. Turning one-shot mode off discards any arm.
- R5: ovf_req and a compare-mode ch_req stay high until their acknowledge (ovf_ack, ch_ack[i]) and fall at the edge after it. A trigger in the same cycle as the acknowledge keeps the request high. Further triggers while a request is pending are absorbed.
- R6: A channel with cap_mode[i]=0 sets ch_req[i] on cmp_match[i] only while oneshot_en is 0. While oneshot_en is 1, it never raises a request.
- R7: A channel with cap_mode[i]=1 sets ch_req[i] on cap_valid[i] and clears it after cap_rd[i]. A valid and a read in the same cycle leave it set. ch_ack[i], cmp_match[i] and oneshot_en have no effect on it.
- R8: In two-ramp mode (cnt_mode=2'b01) with any circ_en bit set, the overflow line triggers on ramp_a_start instead of on update events. A compare channel with circ_en[i]=1 triggers on ramp_b_start instead of on cmp_match[i].
- R9: In dual-slope mode (cnt_mode=2'b10) with any circ_en bit set, the overflow line triggers on up_start. A compare channel with circ_en[i]=1 triggers on down_start.
- R10: For cnt_mode 2'b00 or 2'b11, circ_en has no effect and the phase strobes are ignored. In circular operation, compare channels with circ_en[i]=0 keep the compare-match rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_mode | input | 2 | Counting mode: 00 other, 01 two-ramp, 10 dual-slope, 11 other |
| evt_ovf | input | 1 | Counter overflow strobe |
| evt_unf | input | 1 | Counter underflow strobe |
| evt_retrig | input | 1 | Retrigger strobe |
| ramp_a_start | input | 1 | Start of ramp A strobe |
| ramp_b_start | input | 1 | Start of ramp B strobe |
| up_start | input | 1 | Start of up-counting phase strobe |
| down_start | input | 1 | Start of down-counting phase strobe |
| oneshot_en | input | 1 | One-shot mode enable |
| oneshot_cmd | input | 1 | One-shot command strobe |
| ovf_ack | input | 1 | Acknowledge for the overflow request |
| cmp_match | input | NCH | Per-channel compare match strobes |
| cap_valid | input | NCH | Per-channel captured-data-valid strobes |
| cap_rd | input | NCH | Per-channel capture register read strobes |
| circ_en | input | NCH | Per-channel circular buffer enables |
| cap_mode | input | NCH | Per-channel mode: 1 capture, 0 compare |
| ch_ack | input | NCH | Per-channel acknowledge |
| ovf_req | output | 1 | Overflow DMA request |
| ch_req | output | NCH | Per-channel DMA requests |

## Verification
Every cycle, the assertions check the following. A pending request survives until its own clearing condition. The arm clears while one-shot mode is off. Nothing is raised from an unarmed one-shot or from a compare channel silenced by one-shot mode. A capture channel ignores acknowledge. The choice of which strobe triggers a line in each counting mode is shown only by the bench scenarios. The same holds for the timing of arming relative to the command, and for the cases where acknowledge and trigger coincide. There, a behavioural model of the request rules is compared with the outputs on every clock.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
   typedef enum logic [1:0] {
      CNT_OTHER      = 2'b00,
      CNT_TWO_RAMP   = 2'b01,
      CNT_DUAL_SLOPE = 2'b10,
      CNT_SPARE      = 2'b11
   } cnt_mode_e;

   localparam int unsigned MAX_CH = 8;
endpackage

// File: rtl/tdr_phase_sel.sv
module tdr_phase_sel
   import tdr_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic [1:0]     cnt_mode,
   input  logic [NCH-1:0] circ_en,
   input  logic           evt_ovf,
   input  logic           evt_unf,
   input  logic           evt_retrig,
   input  logic           ramp_a_start,
   input  logic           ramp_b_start,
   input  logic           up_start,
   input  logic           down_start,
   output logic           ovf_trig,
   output logic [NCH-1:0] circ_sel,
   output logic           ch_boundary
);
   cnt_mode_e mode;
   logic      any_circ;
   logic      two_act;
   logic      dual_act;

   always_comb begin
      mode     = cnt_mode_e'(cnt_mode);
      any_circ = |circ_en;
      two_act  = (mode == CNT_TWO_RAMP)   && any_circ;
      dual_act = (mode == CNT_DUAL_SLOPE) && any_circ;
      if (two_act)       ovf_trig = ramp_a_start;
      else if (dual_act) ovf_trig = up_start;
      else               ovf_trig = evt_ovf | evt_unf | evt_retrig;
      ch_boundary = two_act ? ramp_b_start : down_start;
      circ_sel    = (two_act || dual_act) ? circ_en : '0;
   end
endmodule

// File: rtl/tdr_ovf_path.sv
module tdr_ovf_path (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic oneshot_en,
   input  logic oneshot_cmd,
   input  logic ack,
   output logic req
);
   logic armed;
   logic fire;

   assign fire = oneshot_en ? (armed & trig) : trig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req   <= 1'b0;
         armed <= 1'b0;
      end else begin
         req <= fire | (req & ~ack);
         if (!oneshot_en)         armed <= 1'b0;
         else if (oneshot_cmd)    armed <= 1'b1;
         else if (armed && trig)  armed <= 1'b0;
      end
   end

   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req); // R5
   AST_ARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !oneshot_en |=> !armed); // R4
   AST_NO_UNARMED_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_en && !armed && !req |=> !req); // R3
   AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_en && armed && trig && !oneshot_cmd |=> !armed); // R3
endmodule

// File: rtl/tdr_chan.sv
module tdr_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_mode,
   input  logic circ_sel,
   input  logic boundary,
   input  logic cmp_match,
   input  logic cap_valid,
   input  logic cap_rd,
   input  logic ack,
   input  logic oneshot_en,
   output logic req
);
   logic cmp_set;
   logic nxt_cmp;
   logic nxt_cap;

   assign cmp_set = ~oneshot_en & (circ_sel ? boundary : cmp_match);
   assign nxt_cmp = cmp_set | (req & ~ack);
   assign nxt_cap = cap_valid | (req & ~cap_rd);

   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= cap_mode ? nxt_cap : nxt_cmp;
   end

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode && req && !cap_rd |=> req); // R7
   AST_CAP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode && cap_valid |=> req); // R7
   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_mode && req && !ack |=> req); // R5
   AST_OS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_mode && oneshot_en && !req |=> !req); // R6
endmodule

// File: rtl/tmr_dma_req.sv
module tmr_dma_req
   import tdr_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     cnt_mode,
   input  logic           evt_ovf,
   input  logic           evt_unf,
   input  logic           evt_retrig,
   input  logic           ramp_a_start,
   input  logic           ramp_b_start,
   input  logic           up_start,
   input  logic           down_start,
   input  logic           oneshot_en,
   input  logic           oneshot_cmd,
   input  logic           ovf_ack,
   input  logic [NCH-1:0] cmp_match,
   input  logic [NCH-1:0] cap_valid,
   input  logic [NCH-1:0] cap_rd,
   input  logic [NCH-1:0] circ_en,
   input  logic [NCH-1:0] cap_mode,
   input  logic [NCH-1:0] ch_ack,
   output logic           ovf_req,
   output logic [NCH-1:0] ch_req
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("tmr_dma_req: NCH out of range");
   end

   logic           ovf_trig;
   logic [NCH-1:0] circ_sel;
   logic           ch_boundary;

   tdr_phase_sel #(.NCH(NCH)) u_phase (
      .cnt_mode    (cnt_mode),
      .circ_en     (circ_en),
      .evt_ovf     (evt_ovf),
      .evt_unf     (evt_unf),
      .evt_retrig  (evt_retrig),
      .ramp_a_start(ramp_a_start),
      .ramp_b_start(ramp_b_start),
      .up_start    (up_start),
      .down_start  (down_start),
      .ovf_trig    (ovf_trig),
      .circ_sel    (circ_sel),
      .ch_boundary (ch_boundary)
   );

   tdr_ovf_path u_ovf (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (ovf_trig),
      .oneshot_en (oneshot_en),
      .oneshot_cmd(oneshot_cmd),
      .ack        (ovf_ack),
      .req        (ovf_req)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tdr_chan u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap_mode  (cap_mode[i]),
         .circ_sel  (circ_sel[i]),
         .boundary  (ch_boundary),
         .cmp_match (cmp_match[i]),
         .cap_valid (cap_valid[i]),
         .cap_rd    (cap_rd[i]),
         .ack       (ch_ack[i]),
         .oneshot_en(oneshot_en),
         .req       (ch_req[i])
      );
   end

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> !ovf_req && ch_req == '0); // R1
   AST_OTHER_MODE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_mode == 2'b00 && !oneshot_en && evt_ovf |=> ovf_req); // R10
endmodule

// File: tb/sim_tmr_dma_req.sv
module sim_tmr_dma_req;
   localparam int NCH = 4;
   localparam time PERIOD = 10;

   logic clk = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic           rst_n;
   logic [1:0]     cnt_mode;
   logic           evt_ovf, evt_unf, evt_retrig;
   logic           ramp_a_start, ramp_b_start, up_start, down_start;
   logic           oneshot_en, oneshot_cmd, ovf_ack;
   logic [NCH-1:0] cmp_match, cap_valid, cap_rd, circ_en, cap_mode, ch_ack;
   logic           ovf_req;
   logic [NCH-1:0] ch_req;

   tmr_dma_req #(.NCH(NCH)) u0 (.*);

   int n_chk = 0;
   int n_bad = 0;
   string tag = "R1";

   bit m_ovf;
   bit m_arm;
   bit m_ch [NCH];

   task automatic quiet();
      evt_ovf = 0; evt_unf = 0; evt_retrig = 0;
      ramp_a_start = 0; ramp_b_start = 0; up_start = 0; down_start = 0;
      oneshot_cmd = 0; ovf_ack = 0;
      cmp_match = '0; cap_valid = '0; cap_rd = '0; ch_ack = '0;
   endtask

   task automatic tick();
      bit any, two, dual, upd, fire, trig;
      bit n_ovf, n_arm;
      bit n_ch [NCH];
      any  = (circ_en != 0);
      two  = (cnt_mode == 2'b01) && any;
      dual = (cnt_mode == 2'b10) && any;
      if (two)       upd = ramp_a_start;
      else if (dual) upd = up_start;
      else           upd = evt_ovf || evt_unf || evt_retrig;
      if (!rst_n) begin
         n_ovf = 0; n_arm = 0;
         foreach (n_ch[i]) n_ch[i] = 0;
      end else begin
         fire  = oneshot_en ? (m_arm && upd) : upd;
         n_ovf = fire || (m_ovf && !ovf_ack);
         if (!oneshot_en)        n_arm = 0;
         else if (oneshot_cmd)   n_arm = 1;
         else if (m_arm && upd)  n_arm = 0;
         else                    n_arm = m_arm;
         foreach (n_ch[i]) begin
            if (cap_mode[i]) n_ch[i] = cap_valid[i] || (m_ch[i] && !cap_rd[i]);
            else begin
               if ((two || dual) && circ_en[i]) trig = two ? ramp_b_start : down_start;
               else                              trig = cmp_match[i];
               n_ch[i] = (!oneshot_en && trig) || (m_ch[i] && !ch_ack[i]);
            end
         end
      end
      @(posedge clk);
      #1;
      m_ovf = n_ovf; m_arm = n_arm;
      foreach (m_ch[i]) m_ch[i] = n_ch[i];
      n_chk++;
      if (ovf_req !== m_ovf) begin
         n_bad++;
         $display("FAIL %s ovf_req actual %b expected %b at %0t", tag, ovf_req, m_ovf, $time);
      end
      for (int i = 0; i < NCH; i++) begin
         n_chk++;
         if (ch_req[i] !== m_ch[i]) begin
            n_bad++;
            $display("FAIL %s ch_req[%0d] actual %b expected %b at %0t", tag, i, ch_req[i], m_ch[i], $time);
         end
      end
      quiet();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   initial begin
      #(PERIOD*20000);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      quiet();
      rst_n = 0; cnt_mode = 2'b00; oneshot_en = 0;
      circ_en = '0; cap_mode = '0;
      m_ovf = 1; m_arm = 0;
      foreach (m_ch[i]) m_ch[i] = 1;
      // R1: reset clears everything, even with triggers present
      tag = "R1";
      evt_ovf = 1; cmp_match = '1;
      tick(); idle(2);
      rst_n = 1;
      idle(2);

      // R2: each update kind raises ovf_req
      tag = "R2";
      evt_ovf = 1; tick(); idle(2);
      ovf_ack = 1; tick(); idle(1);
      evt_unf = 1; tick(); ovf_ack = 1; tick(); idle(1);
      evt_retrig = 1; tick(); ovf_ack = 1; tick(); idle(1);

      // R5: absorption, ack with simultaneous trigger
      tag = "R5";
      evt_ovf = 1; tick(); evt_ovf = 1; tick(); evt_ovf = 1; ovf_ack = 1; tick();
      idle(1); ovf_ack = 1; tick(); idle(1);
      cmp_match = 4'b0011; tick(); cmp_match = 4'b0001; ch_ack = 4'b0011; tick();
      idle(1); ch_ack = 4'b0001; tick(); idle(1);

      // R6: compare gating by one-shot mode
      tag = "R6";
      cmp_match = 4'b1100; tick(); ch_ack = 4'b1100; tick();
      oneshot_en = 1;
      cmp_match = 4'b1111; tick(); idle(2);

      // R3: arming sequence
      tag = "R3";
      evt_ovf = 1; tick(); idle(1);
      oneshot_cmd = 1; evt_ovf = 1; tick();
      idle(2);
      evt_unf = 1; tick(); idle(1);
      evt_retrig = 1; tick(); idle(1);
      ovf_ack = 1; tick();
      oneshot_cmd = 1; tick(); evt_ovf = 1; ovf_ack = 0; tick(); ovf_ack = 1; tick(); idle(1);

      // R4: command while off, arm discarded when mode drops
      tag = "R4";
      oneshot_en = 0; oneshot_cmd = 1; tick(); oneshot_en = 1; idle(1);
      evt_ovf = 1; tick(); idle(1);
      oneshot_cmd = 1; tick(); oneshot_en = 0; tick(); oneshot_en = 1; idle(1);
      evt_ovf = 1; tick(); idle(1);
      oneshot_en = 0;

      // R7: capture channels
      tag = "R7";
      cap_mode = 4'b0101;
      cap_valid = 4'b0001; tick(); ch_ack = 4'b0001; cmp_match = 4'b0100; tick();
      oneshot_en = 1; cap_valid = 4'b0100; tick(); oneshot_en = 0;
      cap_rd = 4'b0001; cap_valid = 4'b0100; tick(); cap_rd = 4'b0101; cap_valid = 4'b0100; tick();
      cap_rd = 4'b0100; tick(); idle(1);
      cap_mode = '0;

      // R8: two-ramp circular triggers
      tag = "R8";
      cnt_mode = 2'b01; circ_en = 4'b0010;
      evt_ovf = 1; cmp_match = 4'b0010; tick(); idle(1);
      ramp_a_start = 1; tick(); ovf_ack = 1; tick();
      ramp_b_start = 1; tick(); ch_ack = 4'b0010; cmp_match = 4'b0001; tick(); ch_ack = 4'b0001; tick();
      up_start = 1; down_start = 1; tick(); idle(1);
      oneshot_en = 1; ramp_b_start = 1; tick();
      oneshot_cmd = 1; tick(); ramp_a_start = 1; tick(); ovf_ack = 1; tick(); oneshot_en = 0;

      // R9: dual-slope circular triggers
      tag = "R9";
      cnt_mode = 2'b10; circ_en = 4'b1000;
      evt_unf = 1; cmp_match = 4'b1000; ramp_a_start = 1; ramp_b_start = 1; tick(); idle(1);
      up_start = 1; tick(); ovf_ack = 1; tick();
      down_start = 1; cmp_match = 4'b0100; tick(); ch_ack = 4'b1100; tick(); idle(1);

      // R10: other modes ignore circular settings
      tag = "R10";
      cnt_mode = 2'b00;
      ramp_a_start = 1; ramp_b_start = 1; up_start = 1; down_start = 1; tick(); idle(1);
      evt_retrig = 1; cmp_match = 4'b1000; tick(); ovf_ack = 1; ch_ack = 4'b1000; tick();
      cnt_mode = 2'b11;
      up_start = 1; down_start = 1; tick();
      evt_ovf = 1; cmp_match = 4'b1000; tick(); ovf_ack = 1; ch_ack = 4'b1000; tick(); idle(1);
      circ_en = '0; cnt_mode = 2'b01;
      ramp_a_start = 1; evt_ovf = 1; tick(); ovf_ack = 1; tick(); idle(1);

      // R1: mid-run reset
      tag = "R1";
      evt_ovf = 1; cmp_match = '1; tick();
      rst_n = 0; tick(); rst_n = 1; idle(2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule